// File: doc/BRIEF.md
# Banked Memory Mapping Unit

This block sits between an 8-bit CPU core and its external bus. The core issues 16-bit logical addresses, and the block widens each one to a 21-bit physical address. It splits the logical space into eight 8 KB segments, and each segment has its own 8-bit page register. The top three logical bits pick a page register. The value in that register becomes the upper part of the physical address, and the low thirteen logical bits pass through unchanged.

The core loads or inspects any page register through a small indexed register port. Translation is purely combinational against the current register contents.

The physical address is also decoded into three active-low device selects: a video display controller, a video colour encoder and work RAM. The read strobe, the write strobe and an opcode-fetch marker are forwarded to the bus, qualified by the core's request signal.

Top module: `bank_mmu`

## Requirements
- R1: After synchronous reset every page register reads back 0x00 on `pg_rdata`, so all segments map to bank 0.
- R2: Logical bits 15:13 select the page register used for translation: index 0 for 0x0000–0x1FFF up to index 7 for 0xE000–0xFFFF.
- R3: `bus_addr[12:0]` equals `cpu_addr[12:0]` and `bus_addr[20:13]` equals the selected page register value.
- R4: A page-register write with `pg_we` high lands at the next rising clock edge; an access in the same cycle as the write still uses the old value.
- R5: `pg_rdata` returns the page register addressed by `pg_idx` without a clock delay.
- R6: `vdc_cs_n` is low exactly when a request is active, the bank is 0xFF and the offset `bus_addr[12:0]` lies in 0x0000–0x03FF.
- R7: `venc_cs_n` is low exactly when a request is active, the bank is 0xFF and the offset lies in 0x0400–0x07FF.
- R8: `wram_cs_n` is low exactly when a request is active and the bank is 0xF8, for any offset.
- R9: With `cpu_req` low no select is low; at most one select is low at any time.
- R10: `bus_rd_n` is low exactly when `cpu_req` and `cpu_rd` are both high; `bus_wr_n` is low exactly when `cpu_req` and `cpu_wr` are both high.
- R11: `bus_sync` is high exactly when `cpu_req` and `cpu_fetch` are both high, and low for every other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical address from the core |
| cpu_req | input | 1 | Bus access requested this cycle |
| cpu_rd | input | 1 | Access is a read |
| cpu_wr | input | 1 | Access is a write |
| cpu_fetch | input | 1 | Access is an opcode fetch |
| pg_idx | input | 3 | Page register index for the register port |
| pg_wdata | input | 8 | Page register write value |
| pg_we | input | 1 | Page register write enable |
| pg_rdata | output | 8 | Contents of the indexed page register |
| bus_addr | output | 21 | Physical bus address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_sync | output | 1 | High during an opcode fetch |
| vdc_cs_n | output | 1 | Active-low video display controller select |
| venc_cs_n | output | 1 | Active-low colour encoder select |
| wram_cs_n | output | 1 | Active-low work RAM select |

## Verification
The bench sweeps all 65536 logical addresses under two different page layouts. Each layout places bank 0xFF and bank 0xF8 in several segments, so any error in segment selection or page concatenation shows up as a wrong physical address or a misplaced select.

The offsets 0x03FF/0x0400 and 0x07FF/0x0800 inside bank 0xFF are the likeliest off-by-one spots. A decoder that got them wrong would assert two selects at once or leave a gap.

A write to the segment being accessed in the same cycle is checked for both old and new values. A design that bypassed the write would translate early.

Every combination of request, read, write and fetch is driven. Leaking strobes or selects while the request is low would be reported.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;

    parameter int unsigned LOG_W  = 16;
    parameter int unsigned SEG_W  = 3;
    parameter int unsigned PAGE_W = 8;

    localparam int unsigned OFF_W   = LOG_W - SEG_W;
    localparam int unsigned PHYS_W  = PAGE_W + OFF_W;
    localparam int unsigned NUM_SEG = 1 << SEG_W;

    typedef logic [LOG_W-1:0]  log_addr_t;
    typedef logic [PHYS_W-1:0] phys_addr_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [OFF_W-1:0]  off_t;

    // Fixed device windows in physical space
    localparam page_t IO_BANK   = page_t'(8'hFF);
    localparam page_t WRAM_BANK = page_t'(8'hF8);
    localparam off_t  VDC_LAST  = off_t'(13'h03FF);
    localparam off_t  VENC_LAST = off_t'(13'h07FF);

    typedef struct packed {
        logic req;
        logic rd;
        logic wr;
        logic fetch;
    } bus_req_t;

    typedef struct packed {
        logic vdc_n;
        logic venc_n;
        logic wram_n;
    } cs_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_VDC,
        TGT_VENC,
        TGT_WRAM
    } target_e;

    function automatic page_t page_reset_value(input seg_t idx);
        page_reset_value = '0;
        if (idx == seg_t'(NUM_SEG - 1)) page_reset_value = '0;
    endfunction

    function automatic target_e classify(input phys_addr_t pa);
        page_t bank;
        off_t  off;
        bank = pa[PHYS_W-1:OFF_W];
        off  = pa[OFF_W-1:0];
        classify = TGT_NONE;
        if (bank == WRAM_BANK)
            classify = TGT_WRAM;
        else if (bank == IO_BANK && off <= VDC_LAST)
            classify = TGT_VDC;
        else if (bank == IO_BANK && off <= VENC_LAST)
            classify = TGT_VENC;
    endfunction

endpackage

// File: rtl/page_regfile.sv
module page_regfile
    import bank_mmu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  seg_t  widx,
    input  page_t wdata,
    input  seg_t  ridx,
    output page_t rdata,
    input  seg_t  lidx,
    output page_t lpage
);

    page_t pages [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst)
                pages[g] <= page_reset_value(seg_t'(g));
            else if (we && widx == seg_t'(g))
                pages[g] <= wdata;
        end
    end

    assign rdata = pages[ridx];
    assign lpage = pages[lidx];

    // R4: a write is visible on the following cycle
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> pages[$past(widx)] == $past(wdata));

    // R4: without a write the register contents hold
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(lpage) || !$stable(lidx));

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import bank_mmu_pkg::*;
(
    input  log_addr_t  logical,
    input  page_t      page,
    output seg_t       seg,
    output phys_addr_t physical
);

    off_t offset;

    always_comb begin
        seg      = logical[LOG_W-1:OFF_W];
        offset   = logical[OFF_W-1:0];
        physical = {page, offset};
    end

endmodule

// File: rtl/cs_decode.sv
module cs_decode
    import bank_mmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phys_addr_t physical,
    input  bus_req_t   breq,
    output cs_t        cs,
    output logic       rd_n,
    output logic       wr_n,
    output logic       sync
);

    target_e tgt;

    always_comb begin
        tgt = classify(physical);
        cs  = '{vdc_n: 1'b1, venc_n: 1'b1, wram_n: 1'b1};
        if (breq.req) begin
            unique case (tgt)
                TGT_VDC:  cs.vdc_n  = 1'b0;
                TGT_VENC: cs.venc_n = 1'b0;
                TGT_WRAM: cs.wram_n = 1'b0;
                default:  ;
            endcase
        end
        rd_n = !(breq.req && breq.rd);
        wr_n = !(breq.req && breq.wr);
        sync = breq.req && breq.fetch;
    end

    // R9: never more than one device selected
    p_one_select_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs) <= 1);

    // R9: idle bus leaves every select and strobe released
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !breq.req |-> (cs == 3'b111) && rd_n && wr_n && !sync);

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
    import bank_mmu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_req,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic        cpu_fetch,
    input  logic [2:0]  pg_idx,
    input  logic [7:0]  pg_wdata,
    input  logic        pg_we,
    output logic [7:0]  pg_rdata,
    output logic [20:0] bus_addr,
    output logic        bus_rd_n,
    output logic        bus_wr_n,
    output logic        bus_sync,
    output logic        vdc_cs_n,
    output logic        venc_cs_n,
    output logic        wram_cs_n
);

    seg_t       seg;
    page_t      page;
    phys_addr_t physical;
    bus_req_t   breq;
    cs_t        cs;

    assign breq = '{req: cpu_req, rd: cpu_rd, wr: cpu_wr, fetch: cpu_fetch};

    page_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (pg_we),
        .widx  (pg_idx),
        .wdata (pg_wdata),
        .ridx  (pg_idx),
        .rdata (pg_rdata),
        .lidx  (seg),
        .lpage (page)
    );

    addr_xlate u_xlate (
        .logical  (cpu_addr),
        .page     (page),
        .seg      (seg),
        .physical (physical)
    );

    cs_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .physical (physical),
        .breq     (breq),
        .cs       (cs),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .sync     (bus_sync)
    );

    assign bus_addr  = physical;
    assign vdc_cs_n  = cs.vdc_n;
    assign venc_cs_n = cs.venc_n;
    assign wram_cs_n = cs.wram_n;

    // R3: the offset bits reach the bus untouched
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
        bus_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

    // R4: with no page write, a steady logical address gives a steady bus address
    p_map_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !pg_we |=> !$stable(cpu_addr) || $stable(bus_addr));

    // R2: reading the segment's register through the port matches the bank in use
    p_port_matches_r2: assert property (@(posedge clk) disable iff (rst)
        (pg_idx == cpu_addr[15:13]) |-> pg_rdata == bus_addr[20:13]);

endmodule

// File: tb/tb_bank_mmu.sv
module tb_bank_mmu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_req, cpu_rd, cpu_wr, cpu_fetch;
    logic [2:0]  pg_idx;
    logic [7:0]  pg_wdata;
    logic        pg_we;
    logic [7:0]  pg_rdata;
    logic [20:0] bus_addr;
    logic        bus_rd_n, bus_wr_n, bus_sync;
    logic        vdc_cs_n, venc_cs_n, wram_cs_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mmu dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_req(cpu_req),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_fetch(cpu_fetch),
        .pg_idx(pg_idx), .pg_wdata(pg_wdata), .pg_we(pg_we),
        .pg_rdata(pg_rdata), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_sync(bus_sync), .vdc_cs_n(vdc_cs_n),
        .venc_cs_n(venc_cs_n), .wram_cs_n(wram_cs_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_page(input int idx, input logic [7:0] val);
        @(negedge clk);
        pg_idx = 3'(idx); pg_wdata = val; pg_we = 1'b1;
        @(negedge clk);
        pg_we = 1'b0;
        model[idx] = val;
    endtask

    // Full sweep of logical space against the bench's page model
    task automatic sweep(input logic req);
        for (int a = 0; a < 65536; a++) begin
            logic [7:0]  bank;
            logic [12:0] off;
            logic        e_vdc, e_venc, e_wram;
            cpu_addr  = 16'(a);
            cpu_req   = req;
            cpu_rd    = a[0];
            cpu_wr    = ~a[0];
            cpu_fetch = a[1];
            bank = model[a / 8192];
            off  = 13'(a % 8192);
            e_vdc  = req && bank == 8'hFF && off < 13'h0400;
            e_venc = req && bank == 8'hFF && off >= 13'h0400 && off < 13'h0800;
            e_wram = req && bank == 8'hF8;
            #1;
            check("R2/R3 bus_addr", 32'(bus_addr), 32'(bank) * 8192 + 32'(off));
            check("R6/R7/R8/R9 selects", {29'd0, vdc_cs_n, venc_cs_n, wram_cs_n},
                  {29'd0, ~e_vdc, ~e_venc, ~e_wram});
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_req = 0; cpu_rd = 0; cpu_wr = 0;
        cpu_fetch = 0; pg_idx = '0; pg_wdata = '0; pg_we = 0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of every register, and identity into bank 0
        for (int i = 0; i < 8; i++) begin
            pg_idx = 3'(i); #1;
            check("R1 reset page", 32'(pg_rdata), 32'h0);
        end
        cpu_addr = 16'hFFFC; cpu_req = 1; #1;
        check("R1 reset vector bank 0", 32'(bus_addr), 32'h0001FFC);

        // Layout A
        write_page(0, 8'hF8); write_page(1, 8'hFF); write_page(2, 8'h00);
        write_page(3, 8'h7F); write_page(4, 8'h80); write_page(5, 8'hFE);
        write_page(6, 8'hF9); write_page(7, 8'hFF);
        // R5: combinational read port
        for (int i = 0; i < 8; i++) begin
            pg_idx = 3'(i); #1;
            check("R5 read port", 32'(pg_rdata), 32'(model[i]));
        end
        sweep(1'b1);

        // Layout B
        write_page(0, 8'h01); write_page(1, 8'h02); write_page(2, 8'hFF);
        write_page(3, 8'hF8); write_page(4, 8'h40); write_page(5, 8'hFF);
        write_page(6, 8'hF8); write_page(7, 8'h00);
        sweep(1'b1);

        // R9: idle sweep asserts no select
        sweep(1'b0);

        // R4: write and access in the same cycle
        @(negedge clk);
        cpu_req = 1; cpu_addr = 16'h4123;
        pg_idx = 3'd2; pg_wdata = 8'h55; pg_we = 1'b1; #1;
        check("R4 old value same cycle", 32'(bus_addr), 32'hFF * 8192 + 32'h0123);
        @(negedge clk);
        pg_we = 1'b0; model[2] = 8'h55; #1;
        check("R4 new value next cycle", 32'(bus_addr), 32'h55 * 8192 + 32'h0123);
        check("R5 read after write", 32'(pg_rdata), 32'h55);

        // R10/R11: every control combination
        cpu_addr = 16'hA000;
        for (int c = 0; c < 16; c++) begin
            cpu_req = c[3]; cpu_rd = c[2]; cpu_wr = c[1]; cpu_fetch = c[0]; #1;
            check("R10 read strobe", 32'(bus_rd_n), 32'(!(c[3] && c[2])));
            check("R10 write strobe", 32'(bus_wr_n), 32'(!(c[3] && c[1])));
            check("R11 sync", 32'(bus_sync), 32'(c[3] && c[0]));
            check("R9 idle selects", {29'd0, vdc_cs_n, venc_cs_n, wram_cs_n},
                  c[3] ? 32'h3 : 32'h7);
        end

        // R1: reset again returns all pages to zero
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pg_idx = 3'(i); #1;
            check("R1 re-reset page", 32'(pg_rdata), 32'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule